// File: doc/BRIEF.md
# I2C Sensor Register Slave

This block is an I2C target that gives a host access to a bank of eight 8-bit registers beside a light sensor. A fast system clock oversamples SCL and SDA. The block finds start, repeated-start and stop conditions on the bus and answers only to one fixed 7-bit address. The first byte after the address sets a register pointer. Write data bytes then go into the registers. A read, made after a repeated start, returns register contents most significant bit first. The pointer steps by one after every data byte and wraps at the top of the bank.

Registers 2 and 3 are read-only. They take a new sensor result whenever the sensor side pulses its load strobe. All other registers belong to the host. A power-down output is taken from the top three bits of register 0. The block drives SDA only as an open-drain pull-down enable. It never holds SCL low.

Top module: `i2c_sensor_regs`

## Requirements
- R1: The block acknowledges a first byte whose upper seven bits equal binary 1000100 by pulling SDA low in the ninth clock. Bit 0 of that byte selects the transfer direction, with 0 for write and 1 for read.
- R2: After a first byte with any other address, the block leaves SDA released for every following byte until the next start or stop. Register contents do not change.
- R3: A stop (SDA rising while SCL is high) returns the block to idle. A byte cut short by a stop writes nothing. A start or repeated start (SDA falling while SCL is high) always begins a new address byte.
- R4: In a write, the byte after the address sets the pointer from its low 3 bits. Each further byte is stored at the pointer and acknowledged, and then the pointer increments modulo 8.
- R5: In a read, the block shifts out the register at the pointer MSB first. On a master ACK it continues with the next register, and the pointer increments modulo 8.
- R6: A master NACK after a read byte ends the read. SDA stays released until the next start.
- R7: Registers 2 and 3 load sens_lo and sens_hi on a sens_load pulse. Host writes to them are acknowledged but leave their value unchanged.
- R8: The value of a read byte is captured when the byte begins. A sensor load during the byte changes only later reads.
- R9: pwr_down is 1 exactly when bits 7 to 5 of register 0 are all zero.
- R10: sda_oe changes only while SCL is low.
- R11: Reset (rst_n low at a clock edge) clears all registers to 0x00 and releases SDA, so pwr_down reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sens_lo | input | 8 | Sensor result, low byte |
| sens_hi | input | 8 | Sensor result, high byte |
| sens_load | input | 1 | One-cycle strobe that loads both sensor bytes |
| pwr_down | output | 1 | Power-down request decoded from register 0 |

## Verification
The bench builds the block with its default parameters: the address 1000100, two synchronizer stages, an eight-entry bank, and the read-only pair at indices 2 and 3. With eight entries the bench can reach the pointer wrap from 7 to 0 in a single two-byte read. It also writes to both read-only indices from the vector table. A bus quarter period of eight system clocks leaves room for the synchronizer delay. This lets the bench place a sensor load in the middle of a read byte and a stop partway through a write byte.

// File: rtl/i2c_sreg_pkg.sv
// Shared types for the I2C sensor register slave.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_sreg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bus_state_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2c_sreg_sync.sv
// Multi-stage synchronizer for the asynchronous bus lines.
// Assumes: the lines idle high, so every stage resets to 1.
module i2c_sreg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw pad value
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each later stage retimes the one before it
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '1;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_sreg_busmon.sv
// Finds SCL edges and start/stop conditions on the synchronized lines.
// Assumes: its inputs are already synchronous to clk.
module i2c_sreg_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Holds the previous sample of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_sreg_bank.sv
// Register bank: host-writable entries plus two sensor-loaded entries.
// Assumes: one host write per cycle; a sensor load takes priority on its entries.
module i2c_sreg_bank #(
    parameter int NUM_REGS = 8,
    parameter int DW       = 8,
    parameter int AW       = $clog2(NUM_REGS),
    parameter int LO_IDX   = 2,
    parameter int HI_IDX   = 3,
    parameter int PD_BITS  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          load,
    input  logic [DW-1:0] lo_in,
    input  logic [DW-1:0] hi_in,
    output logic          pwr_down
);
    logic [DW-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DW-1:0] r;
        if (g == LO_IDX || g == HI_IDX) begin : g_ro
            // Read-only entry: follows the sensor port on load
            always_ff @(posedge clk) begin
                if (!rst_n)    r <= '0;
                else if (load) r <= (g == LO_IDX) ? lo_in : hi_in;
            end
        end else begin : g_rw
            // Host entry: keeps its value until rewritten
            always_ff @(posedge clk) begin
                if (!rst_n)                             r <= '0;
                else if (we && waddr == AW'(g))         r <= wdata;
            end
        end
        assign regs[g] = r;
    end

    assign rdata    = regs[raddr];
    assign pwr_down = (regs[0][DW-1 -: PD_BITS] == '0);
endmodule

// File: rtl/i2c_sensor_regs.sv
// I2C target in front of the sensor register bank.
// Assumes: SCL is generated by the master only (no stretching); the system
// clock runs many times faster than SCL, so each bus phase lasts several cycles.
module i2c_sensor_regs #(
    parameter logic [6:0] DEV_ADDR = 7'b1000100,
    parameter int         STAGES   = 2,
    parameter int         NUM_REGS = 8,
    parameter int         LO_IDX   = 2,
    parameter int         HI_IDX   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [7:0] sens_lo,
    input  logic [7:0] sens_hi,
    input  logic       sens_load,
    output logic       pwr_down
);
    import i2c_sreg_pkg::*;

    localparam int AW = $clog2(NUM_REGS);
    localparam int CW = $clog2(BYTE_BITS + 1);

    logic             scl_s, sda_s;
    logic             scl_rise, scl_fall, start_det, stop_det;
    bus_state_e       state;
    logic [CW-1:0]    cnt;
    logic [7:0]       shreg;
    logic [AW-1:0]    ptr;
    logic             rw, mack;
    logic             bank_we;
    logic [7:0]       rdata;
    logic             byte_done;

    i2c_sreg_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
    );

    i2c_sreg_busmon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_done = scl_fall && (cnt == CW'(BYTE_BITS));
    assign bank_we   = !start_det && !stop_det && state == ST_WDATA && byte_done;

    i2c_sreg_bank #(
        .NUM_REGS(NUM_REGS), .DW(8), .AW(AW),
        .LO_IDX(LO_IDX), .HI_IDX(HI_IDX), .PD_BITS(3)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(bank_we), .waddr(ptr), .wdata(shreg),
        .raddr(ptr), .rdata(rdata),
        .load(sens_load), .lo_in(sens_lo), .hi_in(sens_hi),
        .pwr_down(pwr_down)
    );

    // Protocol sequencer: bit counting, acknowledge and read shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                state  <= ST_ADDR_ACK;
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end else if (state == ST_PTR) begin
                            ptr    <= shreg[AW-1:0];
                            state  <= ST_PTR_ACK;
                            sda_oe <= 1'b1;
                        end else begin
                            ptr    <= ptr + 1'b1;
                            state  <= ST_WDATA_ACK;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            state  <= ST_RDATA;
                            shreg  <= rdata;
                            sda_oe <= ~rdata[7];
                        end else begin
                            state  <= ST_PTR;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        state  <= ST_WDATA;
                        sda_oe <= 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt    <= '0;
                        state  <= ST_RACK;
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                    end else if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            state  <= ST_RDATA;
                            shreg  <= rdata;
                            sda_oe <= ~rdata[7];
                        end else begin
                            state  <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_sensor_regs_chk.sv
// Protocol checker for the I2C sensor register slave, bound to the top.
// Assumes: it sees the synchronized SCL and the sequencer state.
module i2c_sensor_regs_chk #(
    parameter int AW = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     scl_s,
    input logic                     scl_fall,
    input logic                     sda_oe,
    input i2c_sreg_pkg::bus_state_e state,
    input logic                     start_det,
    input logic                     stop_det,
    input logic                     bank_we,
    input logic [AW-1:0]            bank_waddr,
    input logic                     mack,
    input logic                     pwr_down
);
    import i2c_sreg_pkg::*;

    AST_SDA_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R10

    AST_SILENT_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe); // R2

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe)); // R3

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == ST_ADDR); // R3

    AST_DRIVE_ONLY_ACK_OR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_PTR_ACK ||
                    state == ST_WDATA_ACK || state == ST_RDATA)); // R1

    AST_NACK_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && !mack && !start_det && !stop_det)
        |=> (state == ST_IGNORE && !sda_oe)); // R6

    AST_PD_FOLLOWS_REG0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_down) |-> $past(bank_we && bank_waddr == '0)); // R9
endmodule

bind i2c_sensor_regs i2c_sensor_regs_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
    .sda_oe(sda_oe), .state(state), .start_det(start_det),
    .stop_det(stop_det), .bank_we(bank_we), .bank_waddr(ptr),
    .mack(mack), .pwr_down(pwr_down)
);

// File: tb/i2c_sensor_regs_tb.sv
`timescale 1ns/1ps
module i2c_sensor_regs_tb;
    localparam int         Q     = 8;
    localparam logic [6:0] ADDR  = 7'b1000100;
    localparam int         NVEC  = 8;
    // {pointer, written byte, expected read-back}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h00_A5_A5, 24'h01_3C_3C, 24'h02_FF_00, 24'h03_77_00,
        24'h04_12_12, 24'h07_81_81, 24'h0D_5E_5E, 24'h06_00_00
    };

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] lo_in = '0, hi_in = '0;
    logic load = 1'b0;
    wire  sda_oe, pwr_down;
    wire  sda_line = sda_m & ~sda_oe;
    int   n_chk = 0, n_bad = 0, hi_changes = 0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_sensor_regs u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .sens_lo(lo_in), .sens_hi(hi_in),
        .sens_load(load), .pwr_down(pwr_down)
    );

    // R10 monitor: count sda_oe changes seen while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) hi_changes++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; hold(Q); scl_m = 1'b1; hold(2*Q); scl_m = 1'b0; hold(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
        b = sda_line; hold(Q); scl_m = 1'b0; hold(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(input logic give_ack, input int load_at,
                         input logic [7:0] nlo, input logic [7:0] nhi,
                         output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
            if (7 - i == load_at) begin
                lo_in = nlo; hi_in = nhi; load = 1'b1;
                hold(1); load = 1'b0;
            end
        end
        wbit(~give_ack);
    endtask

    task automatic wr_reg(input logic [7:0] ptr, input logic [7:0] d, output logic all_ack);
        logic a0, a1, a2;
        i2c_start(); wbyte({ADDR, 1'b0}, a0); wbyte(ptr, a1); wbyte(d, a2); i2c_stop();
        all_ack = a0 & a1 & a2;
    endtask

    task automatic rd_reg(input logic [7:0] ptr, output logic [7:0] d);
        logic a;
        i2c_start(); wbyte({ADDR, 1'b0}, a); wbyte(ptr, a);
        i2c_start(); wbyte({ADDR, 1'b1}, a);
        rbyte(1'b0, -1, 8'h00, 8'h00, d); i2c_stop();
    endtask

    initial begin
        logic       ack;
        logic [7:0] d, d2;
        hold(4);
        // R11: reset state
        chk("R11 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
        chk("R9 pwr_down after reset", {7'd0, pwr_down}, 8'h01);
        rst_n = 1'b1; hold(4);
        rd_reg(8'h00, d);
        chk("R11 reg0 after reset", d, 8'h00);

        // Vector table: write then read back (R4, R5, R7)
        for (int i = 0; i < NVEC; i++) begin
            wr_reg(VEC[i][23:16], VEC[i][15:8], ack);
            chk("R1/R4 write acknowledged", {7'd0, ack}, 8'h01);
            rd_reg(VEC[i][23:16], d);
            chk("R4/R5/R7 read-back", d, VEC[i][7:0]);
        end
        chk("R9 pwr_down with reg0=A5", {7'd0, pwr_down}, 8'h00);

        // R2: wrong address is not acknowledged and changes nothing
        i2c_start();
        wbyte({7'b1000101, 1'b0}, ack);
        chk("R2 foreign address nack", {7'd0, ack}, 8'h00);
        wbyte(8'h00, ack);
        chk("R2 pointer byte nack", {7'd0, ack}, 8'h00);
        wbyte(8'h00, ack);
        chk("R2 data byte nack", {7'd0, ack}, 8'h00);
        i2c_stop();
        rd_reg(8'h00, d);
        chk("R2 reg0 unchanged", d, 8'hA5);

        // R3: stop partway through a data byte writes nothing
        i2c_start(); wbyte({ADDR, 1'b0}, ack); wbyte(8'h01, ack);
        wbit(1'b1); wbit(1'b0); wbit(1'b0); wbit(1'b1);
        i2c_stop();
        rd_reg(8'h01, d);
        chk("R3 truncated write ignored", d, 8'h3C);

        // R9: power-down decode from bits 7..5 of reg0
        wr_reg(8'h00, 8'h20, ack); hold(2);
        chk("R9 reg0=20 running", {7'd0, pwr_down}, 8'h00);
        wr_reg(8'h00, 8'h1F, ack); hold(2);
        chk("R9 reg0=1F powered down", {7'd0, pwr_down}, 8'h01);

        // R4: multi-byte write with pointer increment
        i2c_start(); wbyte({ADDR, 1'b0}, ack); wbyte(8'h04, ack);
        wbyte(8'h11, ack); wbyte(8'h22, ack);
        chk("R4 second data byte ack", {7'd0, ack}, 8'h01);
        i2c_stop();
        rd_reg(8'h05, d);
        chk("R4 auto-increment target", d, 8'h22);

        // R5/R6: two-byte read from 7 wraps to 0, ended by NACK
        i2c_start(); wbyte({ADDR, 1'b0}, ack); wbyte(8'h07, ack);
        i2c_start(); wbyte({ADDR, 1'b1}, ack);
        chk("R1 read address ack", {7'd0, ack}, 8'h01);
        rbyte(1'b1, -1, 8'h00, 8'h00, d);
        rbyte(1'b0, -1, 8'h00, 8'h00, d2);
        chk("R5 first read byte reg7", d, 8'h81);
        chk("R5 wrapped read byte reg0", d2, 8'h1F);
        hold(Q);
        chk("R6 SDA released after nack", {7'd0, sda_oe}, 8'h00);
        rbit(ack);
        chk("R6 no drive in extra clock", {7'd0, ack}, 8'h01);
        i2c_stop();

        // R7: sensor load fills the read-only pair
        lo_in = 8'h9A; hi_in = 8'hBC; load = 1'b1; hold(1); load = 1'b0;
        rd_reg(8'h02, d);
        chk("R7 sensor low byte", d, 8'h9A);
        rd_reg(8'h03, d);
        chk("R7 sensor high byte", d, 8'hBC);

        // R8: load during a read byte does not corrupt it
        i2c_start(); wbyte({ADDR, 1'b0}, ack); wbyte(8'h02, ack);
        i2c_start(); wbyte({ADDR, 1'b1}, ack);
        rbyte(1'b0, 3, 8'h44, 8'h55, d);
        i2c_stop();
        chk("R8 shadowed byte", d, 8'h9A);
        rd_reg(8'h02, d);
        chk("R8 new value afterwards", d, 8'h44);

        // R10: no SDA change while SCL high
        chk("R10 changes while SCL high", hi_changes[7:0], 8'h00);

        // R11: reset mid-run clears the bank
        rst_n = 1'b0; hold(3); rst_n = 1'b1; hold(3);
        rd_reg(8'h04, d);
        chk("R11 reg4 cleared", d, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule